// File: doc/BRIEF.md
# Vector Floating-Point to Integer Lane Converter

This block converts a packed vector of IEEE half- or single-precision values into integers of the same lane width, each lane independently. A two-bit size code picks the lane format, an unsigned select picks signed or unsigned results, and a quad select decides whether the full 128-bit operand or only its low 64 bits take part. Conversion always truncates toward zero. Out-of-range values, infinities and NaNs give a defined saturated or zero result and raise a sticky invalid flag. A nonzero discarded fraction raises a sticky inexact flag.

The datapath is one registered stage. An operation presented with `in_valid` high on one rising edge appears on the outputs right after that edge, together with `out_valid`. A reserved size code is reported through `out_undef`; it leaves the result and the sticky flags untouched. The sticky flags gather exceptions from every accepted legal operation and clear only on reset.

Top module: `vec_f2i_conv`

## Requirements
- R1: Size code 2'b01 splits the operand into 16-bit half-precision lanes (lane i at bits 16i+15..16i). Size code 2'b10 splits it into 32-bit single-precision lanes (lane i at bits 32i+31..32i). Result lane i sits at the same bit position as source lane i.
- R2: An operation with size code 2'b00 or 2'b11 gives `out_valid`=1 and `out_undef`=1 one cycle later. It keeps `out_result` and both sticky flags at their previous values. Legal operations give `out_undef`=0.
- R3: A finite value is truncated toward zero. When the result is not saturated and the discarded fraction is nonzero, inexact is raised. A lane never raises invalid and inexact together.
- R4: For a signed conversion, a truncated value above 2^(W-1)-1 gives 2^(W-1)-1, and one below -2^(W-1) gives -2^(W-1) (two's complement). Both raise invalid.
- R5: For an unsigned conversion, a truncated value above 2^W-1 gives all ones and raises invalid. A negative value of magnitude at least 1.0 gives 0 and raises invalid. A negative value of magnitude below 1.0 gives 0 and raises inexact.
- R6: A NaN (exponent all ones, fraction nonzero) gives 0 and raises invalid. An infinity gives the saturated value for its sign and raises invalid.
- R7: A value with a zero exponent field (zero or subnormal) gives 0 and raises no flag.
- R8: With `in_quad`=0, bits 127..64 of the result are zero and lanes in that half raise no flags. With `in_quad`=1, all lanes are converted.
- R9: The result appears one cycle after `in_valid`, and `out_valid` equals `in_valid` delayed by one cycle. While `in_valid` is low, `out_result` holds its value.
- R10: Reset clears `out_valid`, `out_undef`, `out_result` and both sticky flags. After reset, each sticky flag is the OR of the per-lane flags of all accepted legal operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_operand | input | 128 | Packed floating-point source lanes |
| in_size | input | 2 | Lane format code (01 half, 10 single, others reserved) |
| in_unsigned | input | 1 | 1 for unsigned integer results, 0 for signed |
| in_quad | input | 1 | 1 converts 128 bits, 0 converts the low 64 bits |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 128 | Packed integer result lanes |
| out_undef | output | 1 | Reserved size code seen on the reported operation |
| flag_invalid | output | 1 | Sticky invalid-operation flag |
| flag_inexact | output | 1 | Sticky inexact flag |

## Verification
Every one of the 65536 half-precision bit patterns is converted both signed and unsigned. This covers truncation, saturation at both ends, NaN, infinity and flushed subnormals, and separates the signed and unsigned saturation rules. For single precision, every exponent is combined with both signs and a set of fraction patterns (zero, lowest bit only, top bit only, all ones, mixed). This sweeps the integer range boundary near 2^31 and 2^32, where an off-by-one in the overflow comparison shows up. Separate patterns drive NaN into the inactive upper half with the quad select clear, issue reserved size codes carrying exception-raising data, and hold the inputs idle. These tell lane masking, the undefined path and result holding apart from the main conversion.

// File: rtl/vec_f2i_pkg.sv
package vec_f2i_pkg;

    localparam int VEC_W  = 128;
    localparam int HALF_W = 16;
    localparam int HALF_E = 5;
    localparam int HALF_F = 10;
    localparam int SNGL_W = 32;
    localparam int SNGL_E = 8;
    localparam int SNGL_F = 23;

    typedef enum logic [1:0] {
        SZ_RSV_LO = 2'b00,
        SZ_HALF   = 2'b01,
        SZ_SINGLE = 2'b10,
        SZ_RSV_HI = 2'b11
    } lane_size_e;

    typedef struct packed {
        logic invalid;
        logic inexact;
    } exc_flags_t;

    function automatic logic size_is_legal(input lane_size_e sz);
        return (sz == SZ_HALF) || (sz == SZ_SINGLE);
    endfunction

endpackage

// File: rtl/vec_f2i_lane.sv
module vec_f2i_lane #(
    parameter int W  = 16,
    parameter int EW = 5,
    parameter int FW = 10
) (
    input  logic [W-1:0] a,
    input  logic         is_unsigned,
    output logic [W-1:0] y,
    output logic         invalid,
    output logic         inexact
);
    localparam int XW   = FW + W + 2;
    localparam int BIAS = (1 << (EW - 1)) - 1;
    localparam logic [W+1:0] SMAX_X = {3'b000, {(W-1){1'b1}}};
    localparam logic [W+1:0] SNEG_X = {3'b001, {(W-1){1'b0}}};
    localparam logic [W+1:0] UMAX_X = {2'b00, {W{1'b1}}};

    function automatic logic [W-1:0] sat_val(input logic neg, input logic uns);
        if (uns) return neg ? {W{1'b0}} : {W{1'b1}};
        return neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
    endfunction

    logic          sgn;
    logic [EW-1:0] ex;
    logic [FW-1:0] fr;
    logic [XW-1:0] ext;
    logic [W+1:0]  ip;
    logic          frac_nz;
    int            unb;

    assign sgn = a[W-1];
    assign ex  = a[W-2:FW];
    assign fr  = a[FW-1:0];

    always_comb begin
        y       = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        ext     = '0;
        unb     = int'(ex) - BIAS;
        if (ex == {EW{1'b1}}) begin
            invalid = 1'b1;
            if (fr == '0) y = sat_val(sgn, is_unsigned);
        end else if (ex != '0) begin
            if (unb < 0) begin
                inexact = 1'b1;
            end else if (unb > W) begin
                invalid = 1'b1;
                y       = sat_val(sgn, is_unsigned);
            end else begin
                ext = XW'({1'b1, fr}) << unb;
            end
        end
        ip      = ext[XW-1:FW];
        frac_nz = |ext[FW-1:0];
        if (ex != '0 && ex != {EW{1'b1}} && unb >= 0 && unb <= W) begin
            if (is_unsigned) begin
                if (sgn) begin
                    invalid = 1'b1;
                    y       = '0;
                end else if (ip > UMAX_X) begin
                    invalid = 1'b1;
                    y       = '1;
                end else begin
                    y       = ip[W-1:0];
                    inexact = frac_nz;
                end
            end else begin
                if (!sgn && ip > SMAX_X) begin
                    invalid = 1'b1;
                    y       = sat_val(1'b0, 1'b0);
                end else if (sgn && ip > SNEG_X) begin
                    invalid = 1'b1;
                    y       = sat_val(1'b1, 1'b0);
                end else begin
                    y       = sgn ? (W'(0) - ip[W-1:0]) : ip[W-1:0];
                    inexact = frac_nz;
                end
            end
        end
    end

    always_comb begin
        if (!$isunknown({invalid, inexact}))
            a_r3_flags_exclusive: assert (!(invalid && inexact))
                else $error("R3: lane raised invalid and inexact together");
        if (!$isunknown(a) && ex == '0)
            a_r7_flush_zero: assert (y == '0 && !invalid && !inexact)
                else $error("R7: zero-exponent input did not give a clean zero");
    end

endmodule

// File: rtl/vec_f2i_bank.sv
module vec_f2i_bank
    import vec_f2i_pkg::*;
#(
    parameter int DW = 128,
    parameter int W  = 16,
    parameter int EW = 5,
    parameter int FW = 10
) (
    input  logic [DW-1:0] operand,
    input  logic          is_unsigned,
    input  logic          quad,
    output logic [DW-1:0] result,
    output exc_flags_t    flags
);
    localparam int LANES      = DW / W;
    localparam int HALF_LANES = LANES / 2;

    logic [LANES-1:0] act;
    logic [LANES-1:0] inv;
    logic [LANES-1:0] inx;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [W-1:0] y;
        if (g < HALF_LANES) begin : g_low
            assign act[g] = 1'b1;
        end else begin : g_high
            assign act[g] = quad;
        end
        vec_f2i_lane #(.W(W), .EW(EW), .FW(FW)) i_lane (
            .a           (operand[g*W +: W]),
            .is_unsigned (is_unsigned),
            .y           (y),
            .invalid     (inv[g]),
            .inexact     (inx[g])
        );
        assign result[g*W +: W] = act[g] ? y : '0;
    end

    assign flags.invalid = |(inv & act);
    assign flags.inexact = |(inx & act);

endmodule

// File: rtl/vec_f2i_conv.sv
module vec_f2i_conv
    import vec_f2i_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] in_operand,
    input  logic [1:0]   in_size,
    input  logic         in_unsigned,
    input  logic         in_quad,
    output logic         out_valid,
    output logic [127:0] out_result,
    output logic         out_undef,
    output logic         flag_invalid,
    output logic         flag_inexact
);
    lane_size_e       sz;
    logic             legal;
    logic [VEC_W-1:0] h_res, s_res, nxt_res;
    exc_flags_t       h_flg, s_flg, nxt_flg;

    assign sz    = lane_size_e'(in_size);
    assign legal = size_is_legal(sz);

    vec_f2i_bank #(.DW(VEC_W), .W(HALF_W), .EW(HALF_E), .FW(HALF_F)) i_half (
        .operand     (in_operand),
        .is_unsigned (in_unsigned),
        .quad        (in_quad),
        .result      (h_res),
        .flags       (h_flg)
    );

    vec_f2i_bank #(.DW(VEC_W), .W(SNGL_W), .EW(SNGL_E), .FW(SNGL_F)) i_single (
        .operand     (in_operand),
        .is_unsigned (in_unsigned),
        .quad        (in_quad),
        .result      (s_res),
        .flags       (s_flg)
    );

    always_comb begin
        if (sz == SZ_SINGLE) begin
            nxt_res = s_res;
            nxt_flg = s_flg;
        end else begin
            nxt_res = h_res;
            nxt_flg = h_flg;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            out_undef    <= 1'b0;
            out_result   <= '0;
            flag_invalid <= 1'b0;
            flag_inexact <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_undef <= in_valid && !legal;
            if (in_valid && legal) begin
                out_result   <= nxt_res;
                flag_invalid <= flag_invalid | nxt_flg.invalid;
                flag_inexact <= flag_inexact | nxt_flg.inexact;
            end
        end
    end

    a_r2_undef_holds: assert property (@(posedge clk) disable iff (rst)
        in_valid && !legal |=> out_undef && out_valid && $stable(out_result))
        else $error("R2: reserved size changed result or missed undef");

    a_r2_undef_flags: assert property (@(posedge clk) disable iff (rst)
        in_valid && !legal |=> $stable(flag_invalid) && $stable(flag_inexact))
        else $error("R2: reserved size changed sticky flags");

    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
        in_valid && legal && !in_quad |=> out_result[127:64] == '0)
        else $error("R8: upper half nonzero with quad clear");

    a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid)
        else $error("R9: out_valid missing");

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid && !out_undef && $stable(out_result))
        else $error("R9: output moved while idle");

    a_r10_sticky_inv: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |=> flag_invalid)
        else $error("R10: invalid flag fell without reset");

    a_r10_sticky_inx: assert property (@(posedge clk) disable iff (rst)
        flag_inexact |=> flag_inexact)
        else $error("R10: inexact flag fell without reset");

endmodule

// File: tb/test_vec_f2i_conv.sv
module test_vec_f2i_conv;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_operand;
    logic [1:0]   in_size;
    logic         in_unsigned;
    logic         in_quad;
    logic         out_valid;
    logic [127:0] out_result;
    logic         out_undef;
    logic         flag_invalid;
    logic         flag_inexact;

    int n_chk  = 0;
    int n_fail = 0;
    logic [127:0] exp_res;
    bit exp_inv, exp_inx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    vec_f2i_conv i_vec_f2i_conv (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
        .in_size(in_size), .in_unsigned(in_unsigned), .in_quad(in_quad),
        .out_valid(out_valid), .out_result(out_result), .out_undef(out_undef),
        .flag_invalid(flag_invalid), .flag_inexact(flag_inexact)
    );

    // Arithmetic reference for one lane of width w (16 or 32)
    function automatic void ref_lane(input logic [31:0] bits, input int w, input bit uns,
                                     output logic [31:0] y, output bit inv, output bit inx);
        int ew = (w == 16) ? 5 : 8;
        int fw = (w == 16) ? 10 : 23;
        int bias = (1 << (ew - 1)) - 1;
        int emax = (1 << ew) - 1;
        bit sgn = bits[w-1];
        int ex = int'((bits >> fw) & ((32'd1 << ew) - 1));
        longint fr = longint'(bits & ((32'd1 << fw) - 1));
        real v, t;
        real smax = 2.0 ** (w - 1) - 1.0;
        real smin = -(2.0 ** (w - 1));
        real umax = 2.0 ** w - 1.0;
        longint q;
        longint sat;
        y = '0; inv = 0; inx = 0;
        if (uns) sat = sgn ? 64'd0 : ((longint'(1) << w) - 1);
        else     sat = sgn ? (longint'(1) << (w - 1)) : ((longint'(1) << (w - 1)) - 1);
        if (ex == emax) begin
            inv = 1;                                   // R6
            if (fr == 0) y = sat[31:0];
        end else if (ex != 0) begin                    // ex == 0 flushes (R7)
            v = (2.0 ** fw + real'(fr)) * (2.0 ** (ex - bias - fw));
            if (sgn) v = -v;
            t = (v < 0.0) ? -$floor(-v) : $floor(v);   // R3 truncation
            if (uns) begin                             // R5
                if (t < 0.0) inv = 1;
                else if (t > umax) begin inv = 1; y = sat[31:0]; end
                else begin q = longint'(t); y = q[31:0]; inx = (t != v); end
            end else begin                             // R4
                if (t > smax || t < smin) begin inv = 1; y = sat[31:0]; end
                else begin q = longint'(t); y = q[31:0]; inx = (t != v); end
            end
        end
        if (w == 16) y = y & 32'h0000_FFFF;
    endfunction

    task automatic ref_op(input logic [1:0] sz, input bit uns, input bit quad,
                          input logic [127:0] op, output logic [127:0] res,
                          output bit inv, output bit inx);
        int w = (sz == 2'b01) ? 16 : 32;
        int lanes = 128 / w;
        logic [31:0] y;
        bit li, lx;
        res = '0; inv = 0; inx = 0;
        for (int i = 0; i < lanes; i++) begin
            if (quad || i < lanes / 2) begin           // R8 active lanes
                ref_lane(32'((op >> (i * w)) & ((128'd1 << w) - 1)), w, uns, y, li, lx);
                res = res | (128'(y) << (i * w));      // R1 lane i to lane i
                inv = inv | li;
                inx = inx | lx;
            end
        end
    endtask

    task automatic check(input string tag, input bit exp_valid, input bit exp_undef);
        n_chk++;
        if (out_valid !== exp_valid || out_undef !== exp_undef || out_result !== exp_res ||
            flag_invalid !== exp_inv || flag_inexact !== exp_inx) begin
            n_fail++;
            $display("FAIL %s: got v=%0b u=%0b res=%h inv=%0b inx=%0b exp v=%0b u=%0b res=%h inv=%0b inx=%0b",
                     tag, out_valid, out_undef, out_result, flag_invalid, flag_inexact,
                     exp_valid, exp_undef, exp_res, exp_inv, exp_inx);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge after checking
    task automatic run_op(input string tag, input logic [1:0] sz, input bit uns,
                          input bit quad, input logic [127:0] op);
        logic [127:0] r;
        bit li, lx;
        bit legal = (sz == 2'b01) || (sz == 2'b10);
        in_valid = 1; in_size = sz; in_unsigned = uns; in_quad = quad; in_operand = op;
        if (legal) begin
            ref_op(sz, uns, quad, op, r, li, lx);
            exp_res = r; exp_inv = exp_inv | li; exp_inx = exp_inx | lx;
        end
        @(negedge clk);
        check(tag, 1'b1, !legal);
    endtask

    task automatic do_reset();
        in_valid = 0; rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
        exp_res = '0; exp_inv = 0; exp_inx = 0;
        check("R10 reset state", 1'b0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] op;
        logic [22:0] frs [8];
        frs = '{23'h000000, 23'h000001, 23'h400000, 23'h7fffff,
                23'h000400, 23'h200001, 23'h555555, 23'h3ffffe};
        in_operand = '0; in_size = 2'b01; in_unsigned = 0; in_quad = 1; in_valid = 0;
        do_reset();

        // R8: NaN in the upper half with quad clear raises nothing
        run_op("R8 half upper NaN masked", 2'b01, 0, 0, {64'h7E00_7E00_7E00_7E00, 64'h3C00_4000_4200_0000});
        run_op("R8 single upper Inf masked", 2'b10, 1, 0, {64'h7F80_0000_FF80_0000, 64'h4180_0000_3F80_0000});

        // R10: inexact stays set after an exact operation
        run_op("R10 inexact raise", 2'b01, 0, 1, {112'd0, 16'h3E00});
        run_op("R10 inexact sticky", 2'b01, 0, 1, {112'd0, 16'h4000});

        // R2: reserved codes with exception-raising data
        run_op("R2 size 00", 2'b00, 0, 1, {4{32'h7FC0_0000}});
        run_op("R2 size 11", 2'b11, 1, 1, {8{16'hFC00}});

        // R9: idle cycles hold the result
        in_valid = 0; in_operand = {4{32'hDEAD_BEEF}};
        @(negedge clk);
        check("R9 idle hold", 1'b0, 1'b0);
        @(negedge clk);
        check("R9 idle hold 2", 1'b0, 1'b0);

        // R1 R3 R4 R5 R6 R7: every half-precision pattern, signed and unsigned
        for (int u = 0; u < 2; u++) begin
            for (int base = 0; base < 65536; base += 8) begin
                for (int i = 0; i < 8; i++) op[i*16 +: 16] = 16'(base + i);
                run_op(u ? "R1 R5 half unsigned sweep" : "R1 R4 half signed sweep",
                       2'b01, bit'(u), 1, op);
            end
        end

        do_reset();
        // R1 R3 R4 R5 R6 R7: single precision, all exponents, both signs
        for (int u = 0; u < 2; u++) begin
            for (int ex = 0; ex < 256; ex++) begin
                for (int k = 0; k < 4; k++) begin
                    for (int j = 0; j < 4; j++) begin
                        int idx = k * 4 + j;
                        op[j*32 +: 32] = {1'(idx & 1), 8'(ex), frs[idx >> 1]};
                    end
                    run_op(u ? "R1 R5 single unsigned sweep" : "R1 R4 single signed sweep",
                           2'b10, bit'(u), 1, op);
                end
            end
        end

        // R8: quad clear with mixed patterns
        for (int n = 0; n < 64; n++) begin
            op = {4{32'(n * 32'h9E37_79B9 + 32'h3F80_0000)}};
            run_op("R8 quad clear mix", (n % 2) ? 2'b10 : 2'b01, bit'(n / 2 % 2), 0, op);
        end

        in_valid = 0;
        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule